// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every linear address the processor issues and tells the debug logic which of four hardware breakpoints that access has hit. Each breakpoint has an address register and several fields in a shared control register. The fields give a length (1, 2 or 4 bytes, naturally aligned), an access qualifier (instruction fetch, data write, or data read/write), and a local and a global enable. A breakpoint is armed while either of its enables is set. An armed breakpoint hits when any byte of the monitored access overlaps its region and the access kind satisfies its qualifier. Each hit sets a sticky status flag, and the cycle after the access the block raises a one-cycle trap request. A second flag marks the trap as exact when an exact-match bit is set or the hit came from an instruction breakpoint.

Software reaches the registers through a simple select/enable port. The port carries the current privilege level and a real-mode indication, and access is allowed only in real mode or at level 0. A one-shot guard bit turns the next debug-register access of any kind into a fault, even in real mode. That access then clears the guard. A task-switch strobe drops all local enables and the local exact bit, and leaves the global settings alone.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, every address register, the control word and the status flags read 0, and bp_hit, trap_req, trap_exact and reg_fault are 0.
- R2: reg_sel 0..3 selects a breakpoint address register and 4 the status flags (bits 3:0). 5 selects the control word: local enables [3:0], global enables [7:4], local exact bit 8, global exact bit 9, guard bit 10, and for breakpoint i the qualifier at [17+4i:16+4i] and the length at [19+4i:18+4i]. Bits 15:11 always read 0. Reads return data in reg_rdata the cycle after reg_en.
- R3: Length 00 covers 1 byte, 01 covers 2 bytes and 11 covers 4 bytes, with the low address bits ignored so that the region is aligned. An access of acc_size bytes (1..4) hits when any of its bytes falls in the region. Length 10 never matches.
- R4: Access kinds are encoded 00 fetch, 01 read, 10 write. Qualifier 00 matches fetches only, 01 matches writes only, 11 matches reads and writes, and 10 never matches.
- R5: A fetch breakpoint (qualifier 00) matches only when its length is 00.
- R6: A breakpoint is armed when its local or its global enable is set. An unarmed breakpoint sets no status flag and raises no trap.
- R7: A hit sets status flag i in the cycle after the access. The flag stays set until a status write carries 0 in bit i. Writing 1 leaves the flag unchanged.
- R8: trap_req is high for exactly the one cycle after an access that hits an armed breakpoint. trap_exact is high with it when the local or global exact bit is set, or when the hit came from a fetch breakpoint.
- R9: When real_mode is 0 and priv_lvl is not 0, a register access pulses reg_fault the next cycle, writes nothing and returns 0.
- R10: While the guard bit is set, any register access faults (even in real mode), returns 0 and writes nothing, and the guard bit then reads back as 0.
- R11: A task_switch pulse clears all local enables and the local exact bit. The global enables and the global exact bit are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level |
| real_mode | input | 1 | Processor is in real mode |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_fault | output | 1 | Blocked register access, one cycle after the strobe |
| acc_valid | input | 1 | Monitored access present |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 3 | Byte count of the access, 1..4 |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| task_switch | input | 1 | Task-switch strobe |
| bp_hit | output | 4 | Sticky per-breakpoint hit flags |
| trap_req | output | 1 | Debug trap request pulse |
| trap_exact | output | 1 | The trap is exact |

## Verification
Accesses are placed at each edge of 1-, 2- and 4-byte regions, one byte inside and one byte outside. Multi-byte accesses that only partly overlap show whether the unit uses byte overlap or a start-address test, and an unaligned breakpoint address shows whether the low bits are masked. Each breakpoint is driven with fetch, read and write accesses under every qualifier, so each field is decoded from its own bit position. Register accesses are made at ring 3 in protected mode, at ring 3 in real mode and with the guard armed, which separates the privilege test from the one-shot guard.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_BP  = 4;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 3;
  localparam int SIZE_W  = 3;
  localparam int MAX_BYTES = 4;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  localparam logic [1:0] QUAL_EXEC = 2'b00;
  localparam logic [1:0] QUAL_WR   = 2'b01;
  localparam logic [1:0] QUAL_RW   = 2'b11;

  localparam logic [1:0] LEN_1 = 2'b00;
  localparam logic [1:0] LEN_2 = 2'b01;
  localparam logic [1:0] LEN_4 = 2'b11;

  localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(NUM_BP);
  localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(NUM_BP + 1);

  localparam int CB_LOC   = 0;
  localparam int CB_GLB   = NUM_BP;
  localparam int CB_EXL   = 2 * NUM_BP;
  localparam int CB_EXG   = 2 * NUM_BP + 1;
  localparam int CB_GUARD = 2 * NUM_BP + 2;
  localparam int CB_FLD   = 16;
  localparam int FLD_W    = 4;

  localparam logic [REG_W-1:0] CTRL_WMASK =
    {{(REG_W-CB_FLD){1'b1}}, {(CB_FLD-CB_GUARD-1){1'b0}}, {(CB_GUARD+1){1'b1}}};
endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        bp_len,
  input  logic [1:0]        bp_qual,
  input  logic              armed,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        acc_kind,
  output logic              hit
);
  localparam int XW = ADDR_W + 1;

  logic [1:0]    span_m1;
  logic          len_ok;
  logic          kind_ok;
  logic          size_ok;
  logic          overlap;
  logic [XW-1:0] reg_first;
  logic [XW-1:0] reg_last;
  logic [XW-1:0] acc_first;
  logic [XW-1:0] acc_last;

  always_comb begin
    len_ok  = 1'b1;
    span_m1 = 2'd0;
    unique case (bp_len)
      LEN_1:   span_m1 = 2'd0;
      LEN_2:   span_m1 = 2'd1;
      LEN_4:   span_m1 = 2'd3;
      default: len_ok  = 1'b0;
    endcase
  end

  always_comb begin
    kind_ok = 1'b0;
    unique case (bp_qual)
      QUAL_EXEC: kind_ok = (acc_kind == KIND_FETCH) && (bp_len == LEN_1);
      QUAL_WR:   kind_ok = (acc_kind == KIND_WRITE);
      QUAL_RW:   kind_ok = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
      default:   kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    size_ok   = (acc_size != '0) && (acc_size <= SIZE_W'(MAX_BYTES));
    reg_first = {1'b0, bp_addr & ~ADDR_W'(span_m1)};
    reg_last  = reg_first + XW'(span_m1);
    acc_first = {1'b0, acc_addr};
    acc_last  = acc_first + XW'(acc_size) - XW'(1);
    overlap   = (acc_first <= reg_last) && (acc_last >= reg_first);
    hit       = armed && acc_valid && size_ok && len_ok && kind_ok && overlap;
  end
endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_en,
  input  logic                          reg_we,
  input  logic [SEL_W-1:0]              reg_sel,
  input  logic [REG_W-1:0]              reg_wdata,
  input  logic [1:0]                    priv_lvl,
  input  logic                          real_mode,
  input  logic                          task_switch,
  input  logic [NUM_BP-1:0]             hit_vec,
  output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
  output logic [NUM_BP-1:0][1:0]        bp_len,
  output logic [NUM_BP-1:0][1:0]        bp_qual,
  output logic [NUM_BP-1:0]             bp_armed,
  output logic                          exact_any,
  output logic [NUM_BP-1:0]             status,
  output logic [REG_W-1:0]              reg_rdata,
  output logic                          reg_fault
);
  logic [NUM_BP-1:0][ADDR_W-1:0] addr_q, addr_n;
  logic [REG_W-1:0]              ctrl_q, ctrl_n;
  logic [NUM_BP-1:0]             stat_q, stat_n;
  logic [REG_W-1:0]              rdata_q, rdata_n;
  logic                          fault_q, fault_n;
  logic                          allowed;
  logic                          do_wr;
  logic                          do_rd;

  always_comb begin
    allowed = !ctrl_q[CB_GUARD] && (real_mode || (priv_lvl == 2'd0));
    do_wr   = reg_en && reg_we && allowed;
    do_rd   = reg_en && !reg_we && allowed;
    fault_n = reg_en && !allowed;
  end

  always_comb begin
    addr_n = addr_q;
    for (int i = 0; i < NUM_BP; i++) begin
      if (do_wr && (reg_sel == SEL_W'(i))) addr_n[i] = reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (reg_en && ctrl_q[CB_GUARD]) ctrl_n[CB_GUARD] = 1'b0;
    if (do_wr && (reg_sel == SEL_CTRL)) ctrl_n = reg_wdata & CTRL_WMASK;
    if (task_switch) begin
      ctrl_n[CB_LOC +: NUM_BP] = '0;
      ctrl_n[CB_EXL]           = 1'b0;
    end
  end

  always_comb begin
    stat_n = stat_q;
    if (do_wr && (reg_sel == SEL_STATUS)) stat_n = stat_q & reg_wdata[NUM_BP-1:0];
    stat_n = stat_n | hit_vec;
  end

  always_comb begin
    rdata_n = '0;
    if (do_rd) begin
      if (reg_sel < SEL_W'(NUM_BP)) rdata_n = REG_W'(addr_q[reg_sel[1:0]]);
      else if (reg_sel == SEL_STATUS) rdata_n = REG_W'(stat_q);
      else if (reg_sel == SEL_CTRL) rdata_n = ctrl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ctrl_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      addr_q  <= addr_n;
      ctrl_q  <= ctrl_n;
      stat_q  <= stat_n;
      rdata_q <= rdata_n;
      fault_q <= fault_n;
    end
  end

  generate
    for (genvar g = 0; g < NUM_BP; g++) begin : g_fld
      assign bp_qual[g]  = ctrl_q[CB_FLD + FLD_W*g +: 2];
      assign bp_len[g]   = ctrl_q[CB_FLD + FLD_W*g + 2 +: 2];
      assign bp_armed[g] = ctrl_q[CB_LOC + g] | ctrl_q[CB_GLB + g];
    end
  endgenerate

  assign bp_addr   = addr_q;
  assign exact_any = ctrl_q[CB_EXL] | ctrl_q[CB_EXG];
  assign status    = stat_q;
  assign reg_rdata = rdata_q;
  assign reg_fault = fault_q;
endmodule

// File: rtl/bkpt_trap_gen.sv
module bkpt_trap_gen
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BP-1:0] hit_vec,
  input  logic [NUM_BP-1:0] exec_mask,
  input  logic              exact_any,
  output logic              trap_req,
  output logic              trap_exact
);
  logic trap_q, trap_n;
  logic exact_q, exact_n;

  always_comb begin
    trap_n  = |hit_vec;
    exact_n = trap_n && (exact_any || |(hit_vec & exec_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      exact_q <= 1'b0;
    end else begin
      trap_q  <= trap_n;
      exact_q <= exact_n;
    end
  end

  assign trap_req   = trap_q;
  assign trap_exact = exact_q;
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [1:0]        priv_lvl,
  input  logic              real_mode,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_fault,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        acc_kind,
  input  logic              task_switch,
  output logic [NUM_BP-1:0] bp_hit,
  output logic              trap_req,
  output logic              trap_exact
);
  logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
  logic [NUM_BP-1:0][1:0]        bp_len;
  logic [NUM_BP-1:0][1:0]        bp_qual;
  logic [NUM_BP-1:0]             bp_armed;
  logic [NUM_BP-1:0]             hit_vec;
  logic [NUM_BP-1:0]             exec_mask;
  logic                          exact_any;

  bkpt_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .priv_lvl(priv_lvl), .real_mode(real_mode), .task_switch(task_switch),
    .hit_vec(hit_vec),
    .bp_addr(bp_addr), .bp_len(bp_len), .bp_qual(bp_qual), .bp_armed(bp_armed),
    .exact_any(exact_any), .status(bp_hit),
    .reg_rdata(reg_rdata), .reg_fault(reg_fault)
  );

  generate
    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
      bkpt_comparator #(.ADDR_W(ADDR_W)) u_cmp (
        .bp_addr(bp_addr[g]), .bp_len(bp_len[g]), .bp_qual(bp_qual[g]),
        .armed(bp_armed[g]), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .hit(hit_vec[g])
      );
      assign exec_mask[g] = (bp_qual[g] == QUAL_EXEC);
    end
  endgenerate

  bkpt_trap_gen u_trap (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .exec_mask(exec_mask),
    .exact_any(exact_any), .trap_req(trap_req), .trap_exact(trap_exact)
  );
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker
  import bkpt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [1:0]        priv_lvl,
  input logic              real_mode,
  input logic              reg_fault,
  input logic              task_switch,
  input logic [NUM_BP-1:0] bp_hit,
  input logic              trap_req,
  input logic              trap_exact,
  input logic [REG_W-1:0]  ctrl_q
);
  a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault |-> $past(reg_en) &&
      ($past(ctrl_q[CB_GUARD]) || !($past(real_mode) || $past(priv_lvl) == 2'd0)));

  a_r9_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_sel == SEL_CTRL && !real_mode && priv_lvl != 2'd0 &&
     !ctrl_q[CB_GUARD] && !task_switch) |=> $stable(ctrl_q));

  a_r10_guard_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && ctrl_q[CB_GUARD]) |=> !ctrl_q[CB_GUARD]);

  a_r11_local_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> (ctrl_q[CB_LOC +: NUM_BP] == '0) && !ctrl_q[CB_EXL]);

  a_r11_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !reg_en) |=>
      (ctrl_q[CB_GLB +: NUM_BP] == $past(ctrl_q[CB_GLB +: NUM_BP])) &&
      (ctrl_q[CB_EXG] == $past(ctrl_q[CB_EXG])));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && reg_we && reg_sel == SEL_STATUS) |=> ((bp_hit & $past(bp_hit)) == $past(bp_hit)));

  a_r8_trap_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (bp_hit != '0));

  a_r8_exact_with_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_exact |-> trap_req);
endmodule

bind bkpt_match_unit bkpt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel),
  .priv_lvl(priv_lvl), .real_mode(real_mode), .reg_fault(reg_fault),
  .task_switch(task_switch), .bp_hit(bp_hit), .trap_req(trap_req),
  .trap_exact(trap_exact), .ctrl_q(u_regs.ctrl_q)
);

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/1ps
module sim_bkpt_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  priv_lvl = '0;
  logic        real_mode = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_fault;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [1:0]  acc_kind = 2'b01;
  logic        task_switch = 1'b0;
  logic [3:0]  bp_hit;
  logic        trap_req, trap_exact;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10;

  always #2 clk = ~clk;

  bkpt_match_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .priv_lvl(priv_lvl), .real_mode(real_mode),
    .reg_rdata(reg_rdata), .reg_fault(reg_fault), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
    .task_switch(task_switch), .bp_hit(bp_hit), .trap_req(trap_req),
    .trap_exact(trap_exact)
  );

  function automatic logic [31:0] fld(int i, logic [1:0] q, logic [1:0] l);
    return 32'({l, q}) << (16 + 4 * i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] sel, logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] sel);
    reg_en = 1'b1; reg_we = 1'b0; reg_sel = sel;
    cyc();
    reg_en = 1'b0;
  endtask

  task automatic access(logic [31:0] a, logic [2:0] s, logic [1:0] k);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_kind = k;
    cyc();
    acc_valid = 1'b0;
  endtask

  task automatic probe(string tag, logic [31:0] a, logic [2:0] s, logic [1:0] k, logic [3:0] exp);
    access(a, s, k);
    chk({tag, " hit"}, 32'(bp_hit), 32'(exp));
    chk({tag, " trap"}, 32'(trap_req), 32'(exp != 4'd0));
    if (bp_hit != 4'd0) reg_wr(3'd4, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(bp_hit), 0);
    chk("R1 trap", 32'({trap_req, trap_exact, reg_fault}), 0);
    reg_rd(3'd5); chk("R1 ctrl", reg_rdata, 0);
    reg_rd(3'd2); chk("R1 addr2", reg_rdata, 0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 4; i++) reg_wr(3'(i), 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      reg_rd(3'(i)); chk("R2 addr readback", reg_rdata, 32'hA5000000 + 32'(i * 17));
    end
    reg_wr(3'd5, 32'h1234_F8F3);
    reg_rd(3'd5); chk("R2 ctrl mask", reg_rdata, 32'h1234_00F3);
    reg_wr(3'd5, 32'd0);
  endtask

  task automatic t_len();
    reg_wr(3'd0, 32'h1003);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b11, 2'b11));
    probe("R3 len4 inside", 32'h1000, 3'd1, K_R, 4'b0001);
    probe("R3 len4 below", 32'h0FFF, 3'd1, K_R, 4'b0000);
    probe("R3 len4 two below", 32'h0FFE, 3'd2, K_R, 4'b0000);
    probe("R3 len4 straddle low", 32'h0FFF, 3'd2, K_W, 4'b0001);
    probe("R3 len4 above", 32'h1004, 3'd4, K_R, 4'b0000);
    probe("R3 len4 straddle high", 32'h1002, 3'd4, K_R, 4'b0001);
    reg_wr(3'd0, 32'h2001);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b11, 2'b01));
    probe("R3 len2 base", 32'h2000, 3'd1, K_R, 4'b0001);
    probe("R3 len2 above", 32'h2002, 3'd2, K_R, 4'b0000);
    probe("R3 len2 below", 32'h1FFF, 3'd1, K_R, 4'b0000);
    reg_wr(3'd0, 32'h3005);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b11, 2'b00));
    probe("R3 len1 neighbour", 32'h3004, 3'd1, K_R, 4'b0000);
    probe("R3 len1 covered", 32'h3004, 3'd2, K_R, 4'b0001);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b11, 2'b10));
    probe("R3 len reserved", 32'h3004, 3'd4, K_R, 4'b0000);
  endtask

  task automatic t_qual();
    reg_wr(3'd1, 32'h4000);
    reg_wr(3'd5, 32'h20 | fld(1, 2'b01, 2'b00));
    probe("R4 wr-only read", 32'h4000, 3'd1, K_R, 4'b0000);
    probe("R4 wr-only write", 32'h4000, 3'd1, K_W, 4'b0010);
    probe("R4 wr-only fetch", 32'h4000, 3'd1, K_F, 4'b0000);
    reg_wr(3'd5, 32'h20 | fld(1, 2'b10, 2'b00));
    probe("R4 rsvd write", 32'h4000, 3'd1, K_W, 4'b0000);
    probe("R4 rsvd read", 32'h4000, 3'd1, K_R, 4'b0000);
    reg_wr(3'd5, 32'h20 | fld(1, 2'b11, 2'b00));
    probe("R4 rw read", 32'h4000, 3'd1, K_R, 4'b0010);
    probe("R4 rw write", 32'h4000, 3'd1, K_W, 4'b0010);
    probe("R4 rw fetch", 32'h4000, 3'd1, K_F, 4'b0000);
  endtask

  task automatic t_fetch();
    reg_wr(3'd2, 32'h5000);
    reg_wr(3'd5, 32'h40 | fld(2, 2'b00, 2'b00));
    probe("R5 fetch hit", 32'h5000, 3'd1, K_F, 4'b0100);
    probe("R5 fetch bp read", 32'h5000, 3'd1, K_R, 4'b0000);
    reg_wr(3'd5, 32'h40 | fld(2, 2'b00, 2'b11));
    probe("R5 fetch bp len4", 32'h5000, 3'd1, K_F, 4'b0000);
  endtask

  task automatic t_arm();
    reg_wr(3'd3, 32'h6000);
    reg_wr(3'd5, fld(3, 2'b11, 2'b00));
    probe("R6 unarmed", 32'h6000, 3'd1, K_R, 4'b0000);
    reg_wr(3'd5, 32'h08 | fld(3, 2'b11, 2'b00));
    probe("R6 local enable", 32'h6000, 3'd1, K_R, 4'b1000);
    reg_wr(3'd5, 32'h80 | fld(3, 2'b11, 2'b00));
    probe("R6 global enable", 32'h6000, 3'd1, K_R, 4'b1000);
  endtask

  task automatic t_sticky();
    reg_wr(3'd0, 32'h7000);
    reg_wr(3'd1, 32'h7000);
    reg_wr(3'd5, 32'h30 | fld(0, 2'b11, 2'b00) | fld(1, 2'b11, 2'b00));
    access(32'h7000, 3'd1, K_R);
    chk("R7 both set", 32'(bp_hit), 32'h3);
    access(32'h7100, 3'd1, K_R);
    chk("R7 held after miss", 32'(bp_hit), 32'h3);
    reg_rd(3'd4); chk("R7 status read", reg_rdata, 32'h3);
    reg_wr(3'd4, 32'hE);
    chk("R7 clear bit0 only", 32'(bp_hit), 32'h2);
    reg_wr(3'd4, 32'hF);
    chk("R7 write one keeps", 32'(bp_hit), 32'h2);
    reg_wr(3'd4, 32'h0);
    chk("R7 cleared", 32'(bp_hit), 32'h0);
  endtask

  task automatic t_trap();
    reg_wr(3'd0, 32'h8000);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b11, 2'b00));
    access(32'h8000, 3'd1, K_W);
    chk("R8 data trap", 32'({trap_req, trap_exact}), 32'b10);
    cyc();
    chk("R8 trap one cycle", 32'(trap_req), 0);
    reg_wr(3'd4, 0);
    reg_wr(3'd5, 32'h210 | fld(0, 2'b11, 2'b00));
    access(32'h8000, 3'd1, K_W);
    chk("R8 exact global", 32'({trap_req, trap_exact}), 32'b11);
    reg_wr(3'd4, 0);
    reg_wr(3'd5, 32'h110 | fld(0, 2'b11, 2'b00));
    access(32'h8000, 3'd1, K_R);
    chk("R8 exact local", 32'({trap_req, trap_exact}), 32'b11);
    reg_wr(3'd4, 0);
    reg_wr(3'd5, 32'h10 | fld(0, 2'b00, 2'b00));
    access(32'h8000, 3'd1, K_F);
    chk("R8 exact fetch", 32'({trap_req, trap_exact}), 32'b11);
    reg_wr(3'd4, 0);
  endtask

  task automatic t_priv();
    reg_wr(3'd5, 0);
    priv_lvl = 2'd3; real_mode = 1'b0;
    reg_wr(3'd5, 32'h10);
    chk("R9 write fault", 32'(reg_fault), 1);
    reg_rd(3'd5);
    chk("R9 read fault", 32'(reg_fault), 1);
    chk("R9 read zero", reg_rdata, 0);
    priv_lvl = 2'd1;
    reg_wr(3'd0, 32'hDEAD);
    chk("R9 ring1 fault", 32'(reg_fault), 1);
    priv_lvl = 2'd0;
    reg_rd(3'd5); chk("R9 ctrl untouched", reg_rdata, 0);
    chk("R9 ring0 ok", 32'(reg_fault), 0);
    reg_rd(3'd0); chk("R9 addr untouched", reg_rdata, 32'h8000);
    priv_lvl = 2'd3; real_mode = 1'b1;
    reg_wr(3'd5, 32'h10);
    chk("R9 real mode ok", 32'(reg_fault), 0);
    reg_rd(3'd5); chk("R9 real mode write", reg_rdata, 32'h10);
    priv_lvl = 2'd0; real_mode = 1'b0;
  endtask

  task automatic t_guard();
    real_mode = 1'b1;
    reg_wr(3'd5, 32'h420);
    reg_rd(3'd5);
    chk("R10 guarded read fault", 32'(reg_fault), 1);
    chk("R10 guarded read zero", reg_rdata, 0);
    reg_rd(3'd5);
    chk("R10 guard cleared", reg_rdata, 32'h20);
    chk("R10 no fault after", 32'(reg_fault), 0);
    reg_wr(3'd5, 32'h400);
    reg_wr(3'd5, 32'h80);
    chk("R10 guarded write fault", 32'(reg_fault), 1);
    reg_rd(3'd5);
    chk("R10 write ignored", reg_rdata, 0);
    real_mode = 1'b0;
  endtask

  task automatic t_task();
    reg_wr(3'd5, 32'h3AF);
    task_switch = 1'b1;
    cyc();
    task_switch = 1'b0;
    reg_rd(3'd5);
    chk("R11 task switch", reg_rdata, 32'h2A0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_len();
    t_qual();
    t_fetch();
    t_arm();
    t_sticky();
    t_trap();
    t_priv();
    t_guard();
    t_task();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule